// File: doc/BRIEF.md
# Data-Bus Address Decoder and Response Steering Fabric

This block connects one data-side bus master to two slaves: a 32 KB single-cycle RAM that can never stall, and a small memory-mapped coprocessor that may hold off an access with a wait-request. From the master's byte address it decides which slave is targeted. It raises only that slave's read or write strobe and gives it a word address local to that slave. It returns a wait-request to the master that only the coprocessor can raise.

The master expects read data exactly one cycle after a read is accepted. The RAM meets this timing by itself. The fabric captures the coprocessor's data in the cycle its read completes and presents it one cycle later. A small state machine remembers, at each accepted read, which source must drive the master's read-data port in the following cycle. Its states are RS_IDLE (nothing returning, data is zero), RS_RAM (pass RAM data), RS_COP (present the captured coprocessor word) and RS_ZERO (an unmapped read returns zero).

The state is set every cycle from the acceptance just seen, so any state can move to any other. The transitions are:
- T_ACC_RAM, on an accepted RAM read, goes to RS_RAM.
- T_ACC_COP, on a coprocessor read with wait-request low, goes to RS_COP.
- T_ACC_NONE, on a read to an unmapped address, goes to RS_ZERO.
- T_NO_READ, on no accepted read (idle, write, or stalled read), goes to RS_IDLE.
- Reset enters RS_IDLE.

Top module: `dbus_fabric`

## Requirements
- R1: A byte address in 0x0000–0x7FFF asserts only the RAM strobe matching the master's read or write, with RAM word address equal to byte address bits [14:2]; coprocessor strobes stay low.
- R2: A byte address in 0xA000–0xA023 asserts only the coprocessor strobe matching the master's request, with coprocessor word address (address − 0xA000) >> 2, ranging 0 to 8; RAM strobes stay low.
- R3: Any other address asserts no slave strobe and never stalls the master, and a read there returns 0x00000000 on the master's read data in the next cycle.
- R4: The master's wait-request equals the coprocessor's wait-request while a read or write targets the coprocessor, and is 0 for RAM accesses, unmapped accesses and idle cycles.
- R5: While the coprocessor holds wait-request high and the master holds its request, the coprocessor strobe and word address stay asserted every cycle.
- R6: The cycle after a RAM read is issued, the master's read data equals the RAM's read data of that cycle.
- R7: The cycle after a coprocessor read completes (wait-request low), the master's read data equals the coprocessor data sampled in the completing cycle, even if the coprocessor's data then changes.
- R8: After reset, and in every cycle that does not follow an accepted read, the master's read data is 0x00000000.
- R9: Write data and byte enables reach both slaves unchanged.
- R10: Back-to-back reads to different slaves each return their own data, because the return source is chosen when each read is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| m_addr | input | 16 | Master byte address |
| m_read | input | 1 | Master read request |
| m_write | input | 1 | Master write request |
| m_wdata | input | 32 | Master write data |
| m_be | input | 4 | Master byte enables |
| m_rdata | output | 32 | Read data to master, one cycle after acceptance |
| m_waitreq | output | 1 | Stall to master |
| ram_addr | output | 13 | RAM word address |
| ram_read | output | 1 | RAM read strobe |
| ram_write | output | 1 | RAM write strobe |
| ram_wdata | output | 32 | RAM write data |
| ram_be | output | 4 | RAM byte enables |
| ram_rdata | input | 32 | RAM read data, valid one cycle after read strobe |
| cp_addr | output | 4 | Coprocessor word address |
| cp_read | output | 1 | Coprocessor read strobe |
| cp_write | output | 1 | Coprocessor write strobe |
| cp_wdata | output | 32 | Coprocessor write data |
| cp_be | output | 4 | Coprocessor byte enables |
| cp_rdata | input | 32 | Coprocessor read data, valid while wait-request is low |
| cp_waitreq | input | 1 | Coprocessor stall |

## Verification
The only internal state is the return-source state and the captured coprocessor word. If either is wrong, the fault appears on the master's read data in the very next cycle. A mis-steered state shows the other slave's data or a stale word instead of zero. A missing capture shows the coprocessor's current data instead of the data it had at completion. The bench changes the coprocessor's data right after completion and follows reads to different slaves back to back, so both faults are seen one cycle after the read. Decode faults show at once as wrong strobes, addresses or wait-request in the same cycle.

// File: rtl/dbus_pkg.sv
package dbus_pkg;

    // source that drives the master's read data in the cycle after a read
    typedef enum logic [1:0] {
        RS_IDLE = 2'd0,
        RS_RAM  = 2'd1,
        RS_COP  = 2'd2,
        RS_ZERO = 2'd3
    } rsp_state_t;

    // one-cycle pulses: a read was accepted this cycle, by target
    typedef struct packed {
        logic ram;
        logic cop;
        logic none;
    } rd_accept_t;

endpackage

// File: rtl/dbus_decode.sv
module dbus_decode
    import dbus_pkg::*;
#(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned RAM_BYTES = 32768,
    parameter int unsigned CP_BASE   = 32'hA000,
    parameter int unsigned CP_WORDS  = 9,
    parameter int unsigned RAM_AW    = $clog2(RAM_BYTES / 4),
    parameter int unsigned CP_AW     = $clog2(CP_WORDS)
) (
    input  logic [ADDR_W-1:0] m_addr,
    input  logic              m_read,
    input  logic              m_write,
    input  logic              cp_waitreq,
    output logic [RAM_AW-1:0] ram_addr,
    output logic              ram_read,
    output logic              ram_write,
    output logic [CP_AW-1:0]  cp_addr,
    output logic              cp_read,
    output logic              cp_write,
    output logic              m_waitreq,
    output rd_accept_t        rd_acc
);

    localparam int unsigned CP_END = CP_BASE + CP_WORDS * 4;

    logic [31:0] addr32;
    logic [31:0] cp_off;
    logic        hit_ram;
    logic        hit_cp;

    always_comb begin
        addr32  = 32'(m_addr);
        cp_off  = (addr32 - CP_BASE) >> 2;
        hit_ram = (addr32 < RAM_BYTES);
        hit_cp  = (addr32 >= CP_BASE) && (addr32 < CP_END);
    end

    always_comb begin
        ram_addr  = m_addr[RAM_AW+1:2];
        cp_addr   = cp_off[CP_AW-1:0];
        ram_read  = hit_ram && m_read;
        ram_write = hit_ram && m_write;
        cp_read   = hit_cp && m_read;
        cp_write  = hit_cp && m_write;
        // only the coprocessor may stall, and only while it is addressed
        m_waitreq = hit_cp && (m_read || m_write) && cp_waitreq;
        rd_acc.ram  = hit_ram && m_read;
        rd_acc.cop  = hit_cp && m_read && !cp_waitreq;
        rd_acc.none = m_read && !hit_ram && !hit_cp;
    end

endmodule

// File: rtl/dbus_rsp.sv
module dbus_rsp
    import dbus_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  rd_accept_t        rd_acc,
    input  logic [DATA_W-1:0] ram_rdata,
    input  logic [DATA_W-1:0] cp_rdata,
    output logic [DATA_W-1:0] m_rdata
);

    rsp_state_t        state_q;
    rsp_state_t        state_d;
    logic [DATA_W-1:0] cp_hold_q;

    // next state: chosen from the read accepted in this cycle
    always_comb begin
        state_d = RS_IDLE;                    // T_NO_READ
        if (rd_acc.ram)       state_d = RS_RAM;   // T_ACC_RAM
        else if (rd_acc.cop)  state_d = RS_COP;   // T_ACC_COP
        else if (rd_acc.none) state_d = RS_ZERO;  // T_ACC_NONE
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= RS_IDLE;
            cp_hold_q <= '0;
        end else begin
            state_q <= state_d;
            if (rd_acc.cop) cp_hold_q <= cp_rdata;
        end
    end

    always_comb begin
        unique case (state_q)
            RS_IDLE: m_rdata = '0;
            RS_RAM:  m_rdata = ram_rdata;
            RS_COP:  m_rdata = cp_hold_q;
            RS_ZERO: m_rdata = '0;
            default: m_rdata = '0;
        endcase
    end

    AST_RAM_RETURN: assert property (@(posedge clk) disable iff (rst)
        rd_acc.ram |=> (m_rdata == ram_rdata)); // R6

    AST_COP_RETURN: assert property (@(posedge clk) disable iff (rst)
        rd_acc.cop |=> (m_rdata == $past(cp_rdata))); // R7

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        rd_acc.none |=> (m_rdata == '0)); // R3

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !(rd_acc.ram || rd_acc.cop || rd_acc.none) |=> (m_rdata == '0)); // R8

endmodule

// File: rtl/dbus_fabric.sv
module dbus_fabric
    import dbus_pkg::*;
#(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned RAM_BYTES = 32768,
    parameter int unsigned CP_BASE   = 32'hA000,
    parameter int unsigned CP_WORDS  = 9,
    parameter int unsigned BE_W      = DATA_W / 8,
    parameter int unsigned RAM_AW    = $clog2(RAM_BYTES / 4),
    parameter int unsigned CP_AW     = $clog2(CP_WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] m_addr,
    input  logic              m_read,
    input  logic              m_write,
    input  logic [DATA_W-1:0] m_wdata,
    input  logic [BE_W-1:0]   m_be,
    output logic [DATA_W-1:0] m_rdata,
    output logic              m_waitreq,
    output logic [RAM_AW-1:0] ram_addr,
    output logic              ram_read,
    output logic              ram_write,
    output logic [DATA_W-1:0] ram_wdata,
    output logic [BE_W-1:0]   ram_be,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic [CP_AW-1:0]  cp_addr,
    output logic              cp_read,
    output logic              cp_write,
    output logic [DATA_W-1:0] cp_wdata,
    output logic [BE_W-1:0]   cp_be,
    input  logic [DATA_W-1:0] cp_rdata,
    input  logic              cp_waitreq
);

    rd_accept_t rd_acc;

    assign ram_wdata = m_wdata;
    assign ram_be    = m_be;
    assign cp_wdata  = m_wdata;
    assign cp_be     = m_be;

    dbus_decode #(
        .ADDR_W    (ADDR_W),
        .RAM_BYTES (RAM_BYTES),
        .CP_BASE   (CP_BASE),
        .CP_WORDS  (CP_WORDS),
        .RAM_AW    (RAM_AW),
        .CP_AW     (CP_AW)
    ) u_decode (
        .m_addr     (m_addr),
        .m_read     (m_read),
        .m_write    (m_write),
        .cp_waitreq (cp_waitreq),
        .ram_addr   (ram_addr),
        .ram_read   (ram_read),
        .ram_write  (ram_write),
        .cp_addr    (cp_addr),
        .cp_read    (cp_read),
        .cp_write   (cp_write),
        .m_waitreq  (m_waitreq),
        .rd_acc     (rd_acc)
    );

    dbus_rsp #(
        .DATA_W (DATA_W)
    ) u_rsp (
        .clk       (clk),
        .rst       (rst),
        .rd_acc    (rd_acc),
        .ram_rdata (ram_rdata),
        .cp_rdata  (cp_rdata),
        .m_rdata   (m_rdata)
    );

    AST_RAM_NO_STALL: assert property (@(posedge clk) disable iff (rst)
        (ram_read || ram_write) |-> !m_waitreq); // R4

    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (rst)
        !(m_read && m_write) |-> $onehot0({ram_read, ram_write, cp_read, cp_write})); // R1

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !(m_read || m_write) |-> !(ram_read || ram_write || cp_read || cp_write || m_waitreq)); // R4

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (m_waitreq && m_read) ##1 (m_read && $stable(m_addr)) |-> cp_read); // R5

endmodule

// File: tb/sim_dbus_fabric.sv
`timescale 1ns/100ps
module sim_dbus_fabric;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] m_addr = '0;
    logic        m_read = 1'b0;
    logic        m_write = 1'b0;
    logic [31:0] m_wdata = '0;
    logic [3:0]  m_be = '0;
    logic [31:0] m_rdata;
    logic        m_waitreq;
    logic [12:0] ram_addr;
    logic        ram_read, ram_write;
    logic [31:0] ram_wdata;
    logic [3:0]  ram_be;
    logic [31:0] ram_rdata = '0;
    logic [3:0]  cp_addr;
    logic        cp_read, cp_write;
    logic [31:0] cp_wdata;
    logic [3:0]  cp_be;
    logic [31:0] cp_rdata = '0;
    logic        cp_waitreq = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    dbus_fabric u0 (
        .clk(clk), .rst(rst),
        .m_addr(m_addr), .m_read(m_read), .m_write(m_write),
        .m_wdata(m_wdata), .m_be(m_be), .m_rdata(m_rdata), .m_waitreq(m_waitreq),
        .ram_addr(ram_addr), .ram_read(ram_read), .ram_write(ram_write),
        .ram_wdata(ram_wdata), .ram_be(ram_be), .ram_rdata(ram_rdata),
        .cp_addr(cp_addr), .cp_read(cp_read), .cp_write(cp_write),
        .cp_wdata(cp_wdata), .cp_be(cp_be), .cp_rdata(cp_rdata),
        .cp_waitreq(cp_waitreq)
    );

    // behavioural RAM: one-cycle read latency, data = 0x5A000000 | word address
    always @(posedge clk) begin
        if (ram_read) ram_rdata <= 32'h5A00_0000 | 32'(ram_addr);
        else          ram_rdata <= 32'hDEAD_BEEF;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [15:0] a, input logic rd, input logic wr, input logic cw);
        m_addr = a; m_read = rd; m_write = wr; cp_waitreq = cw;
    endtask

    // {addr[15:0], rd, wr, cp_waitreq, exp ram_rd, ram_wr, cp_rd, cp_wr, waitreq, exp word addr[15:0]}
    localparam logic [39:0] VT [12] = '{
        {16'h0000, 3'b100, 5'b10000, 16'h0000},
        {16'h7FFC, 3'b010, 5'b01000, 16'h1FFF},
        {16'h7FFF, 3'b100, 5'b10000, 16'h1FFF},
        {16'h8000, 3'b101, 5'b00000, 16'h0000},
        {16'hA000, 3'b100, 5'b00100, 16'h0000},
        {16'hA020, 3'b011, 5'b00011, 16'h0008},
        {16'hA023, 3'b101, 5'b00101, 16'h0008},
        {16'hA024, 3'b101, 5'b00000, 16'h0000},
        {16'h9FFC, 3'b011, 5'b00000, 16'h0000},
        {16'h4000, 3'b011, 5'b01000, 16'h1000},
        {16'h0000, 3'b001, 5'b00000, 16'h0000},
        {16'hA010, 3'b100, 5'b00100, 16'h0004}
    };

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R8 reset rdata", m_rdata, 32'h0);
        chk("R4 reset waitreq", 32'(m_waitreq), 32'h0);
        @(negedge clk);
        rst = 1'b0;

        // table walk: decode, local addresses and wait-request
        for (int i = 0; i < 12; i++) begin
            logic [39:0] v;
            string tag;
            v = VT[i];
            drive(v[39:24], v[23], v[22], v[21]);
            #1;
            tag = v[20:19] != 2'b00 ? "R1" : (v[18:17] != 2'b00 ? "R2" : "R3");
            chk({tag, " strobes"}, 32'({ram_read, ram_write, cp_read, cp_write}), 32'(v[20:17]));
            chk("R4 waitreq", 32'(m_waitreq), 32'(v[16]));
            if (v[20:19] != 2'b00) chk("R1 ram word addr", 32'(ram_addr), 32'(v[15:0]));
            if (v[18:17] != 2'b00) chk("R2 cp word addr", 32'(cp_addr), 32'(v[15:0]));
            @(negedge clk);
        end
        drive(16'h0, 0, 0, 0);
        @(negedge clk);

        // R9: write data and byte enables forwarded
        m_wdata = 32'hA5C3_0F96; m_be = 4'b1010; drive(16'h0010, 0, 1, 0);
        #1;
        chk("R9 ram wdata", ram_wdata, 32'hA5C3_0F96);
        chk("R9 cp wdata", cp_wdata, 32'hA5C3_0F96);
        chk("R9 be", 32'({ram_be, cp_be}), 32'hAA);
        @(negedge clk);

        // R6: RAM read returns next cycle
        drive(16'h1234, 1, 0, 0);
        @(negedge clk);
        drive(16'h0, 0, 0, 0);
        #1;
        chk("R6 ram return", m_rdata, 32'h5A00_048D);
        @(negedge clk);
        #1;
        chk("R8 idle after read", m_rdata, 32'h0);

        // R5/R4: stalled coprocessor read, then R7 capture
        drive(16'hA008, 1, 0, 1);
        cp_rdata = 32'h3F80_0000;
        for (int k = 0; k < 3; k++) begin
            #1;
            chk("R4 stall passes", 32'(m_waitreq), 32'h1);
            chk("R5 strobe held", 32'({cp_read, cp_addr}), 32'h12);
            @(negedge clk);
            #1;
            chk("R8 no data while stalled", m_rdata, 32'h0);
        end
        cp_waitreq = 1'b0;
        #1;
        chk("R4 release", 32'(m_waitreq), 32'h0);
        @(negedge clk);
        drive(16'h0, 0, 0, 0);
        cp_rdata = 32'h1111_1111;
        #1;
        chk("R7 captured cp data", m_rdata, 32'h3F80_0000);
        @(negedge clk);

        // R10: RAM read then coprocessor read back to back
        drive(16'h0008, 1, 0, 0);
        cp_rdata = 32'hC0DE_0001;
        @(negedge clk);
        drive(16'hA020, 1, 0, 0);
        #1;
        chk("R10 first (ram)", m_rdata, 32'h5A00_0002);
        @(negedge clk);
        drive(16'h0, 0, 0, 0);
        cp_rdata = 32'h0;
        #1;
        chk("R10 second (cp)", m_rdata, 32'hC0DE_0001);
        @(negedge clk);

        // R3: unmapped read after a RAM read, with coprocessor stalling
        drive(16'h0100, 1, 0, 1);
        @(negedge clk);
        drive(16'h9000, 1, 0, 1);
        #1;
        chk("R3 no stall unmapped", 32'(m_waitreq), 32'h0);
        chk("R6 ram before unmapped", m_rdata, 32'h5A00_0040);
        @(negedge clk);
        drive(16'h0, 0, 0, 0);
        #1;
        chk("R3 unmapped returns zero", m_rdata, 32'h0);
        @(negedge clk);

        // R4: coprocessor write stalls, RAM write never does
        drive(16'hA004, 0, 1, 1);
        #1;
        chk("R4 cp write stall", 32'({m_waitreq, cp_write}), 32'h3);
        @(negedge clk);
        drive(16'h0004, 0, 1, 1);
        #1;
        chk("R4 ram write no stall", 32'({m_waitreq, ram_write}), 32'h1);
        @(negedge clk);
        drive(16'h0, 0, 0, 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule